// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers sixteen maskable external request lines and one nonmaskable line for a processor core. Every pin passes through a two-stage synchroniser. Each maskable line then has a detector whose sense mode can be programmed separately. A detected request sets a sticky status flag. The flag is gated by an enable bit for its line. An arbiter picks the most urgent enabled line by programmable level and offers it to the core, provided its level beats the core's current mask.

The nonmaskable line has its own edge selector. A request on it stays pending until the core acknowledges it. While pending, it takes the core's attention whatever the mask and the enable settings are. Software drives a small register port to set the modes, enables, levels and NMI edge, and to clear the status flags with a read-then-write-zero sequence. Any pending request that is allowed through, including the nonmaskable one, raises a wake output so that clocking can resume after a standby state.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, all status flags, the NMI pending bit, the enables, the levels and the sense fields are 0. The NMI edge control at address 0 bit 0 is 0, which selects the falling edge. The outputs int_req, int_nmi, int_index, int_level and wake are 0.
- R2: The sense field of line i sits at address 1, bits [2i+1:2i]. Code 01 sets flag i on a falling edge of the synchronised pin, code 10 on a rising edge, and code 11 on either edge. An edge of the other polarity leaves the flag unchanged.
- R3: With sense code 00, flag i is set in every cycle that the synchronised pin is low. The flag therefore reasserts while the pin is held low.
- R4: Flag i can be read at address 5, bit i. Writing 0 to bit i clears it only if a read strobe at address 5 has seen the flag as 1 since the last clear. Writing 1 has no effect. A flag falls only through such a write, and a set in the same cycle as the clear wins.
- R5: The enable bit of line i sits at address 2, bit i. A line whose enable is 0 still sets its flag, but it is never offered to the core.
- R6: The level of line i is in bits [4k+2:4k], with k = i mod 8, at address 3 for lines 0 to 7 and at address 4 for lines 8 to 15. Among enabled pending lines, the highest level wins, and on a tie the lower line number wins. int_index gives the line number and int_level gives its level.
- R7: A maskable request is presented only when its level is strictly greater than cpu_mask. Otherwise int_req, int_index and int_level are 0 (unless the NMI is pending).
- R8: The NMI pending bit is set on the selected edge (address 0 bit 0: 0 selects falling, 1 selects rising) and is cleared by nmi_ack. While it is set, int_req=1, int_nmi=1, int_index=16 and int_level=7, whatever the mask and the enables. The bit can be read at address 6, bit 0.
- R9: wake is 1 whenever the NMI is pending or any enabled flag is set, whatever the value of cpu_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Nonmaskable request pin |
| irq_pin | input | 16 | Maskable request pins |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks flags as seen) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| cpu_mask | input | 3 | Current core priority mask |
| nmi_ack | input | 1 | Core acknowledges the NMI |
| int_req | output | 1 | A request is offered to the core |
| int_nmi | output | 1 | The offered request is the NMI |
| int_index | output | 5 | Offered line (16 for NMI) |
| int_level | output | 3 | Level of the offered request |
| wake | output | 1 | Standby exit request |

## Verification
The hardest case to reach is a flag being set in the same cycle that software clears it. The bench reaches it by using level sense on a pin held low, which sets the flag in every cycle. It then issues the read strobe and the zero write, and expects the flag to survive. Ties in the arbiter are produced by dropping two lines of equal level in the same cycle. The NMI edge selector is checked by driving the edge that was not selected first and observing that nothing becomes pending.

// File: rtl/eirq_ctrl.sv
module eirq_ctrl #(
  parameter int N_IRQ = 16,
  parameter int LVL_W = 3,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic [N_IRQ-1:0] irq_pin,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [LVL_W-1:0] cpu_mask,
  input  logic             nmi_ack,
  output logic             int_req,
  output logic             int_nmi,
  output logic [$clog2(N_IRQ+1)-1:0] int_index,
  output logic [LVL_W-1:0] int_level,
  output logic             wake
);
  localparam int IDX_W = $clog2(N_IRQ+1);
  localparam int HALF  = N_IRQ / 2;

  logic [N_IRQ:0]     s1, s2, s3;
  logic               nmi_rise, nmi_pend, nmi_set;
  logic [1:0]         sense [N_IRQ];
  logic [LVL_W-1:0]   prio  [N_IRQ];
  logic [N_IRQ-1:0]   en, flag, seen, set, clr, flag_nx, pend, fall, rise;
  logic               found, mreq;
  logic [IDX_W-1:0]   best_idx;
  logic [LVL_W-1:0]   best_lvl;
  logic               wr_flag, rd_flag;

  assign fall    = s3[N_IRQ-1:0] & ~s2[N_IRQ-1:0];
  assign rise    = ~s3[N_IRQ-1:0] & s2[N_IRQ-1:0];
  assign nmi_set = nmi_rise ? (~s3[N_IRQ] & s2[N_IRQ]) : (s3[N_IRQ] & ~s2[N_IRQ]);
  assign wr_flag = reg_wr && reg_addr == AW'(5);
  assign rd_flag = reg_rd && reg_addr == AW'(5);
  assign clr     = wr_flag ? (seen & ~reg_wdata[N_IRQ-1:0]) : '0;
  assign flag_nx = (flag & ~clr) | set;
  assign pend    = flag & en;

  always_comb begin
    for (int i = 0; i < N_IRQ; i++) begin
      case (sense[i])
        2'b00:   set[i] = ~s2[i];
        2'b01:   set[i] = fall[i];
        2'b10:   set[i] = rise[i];
        default: set[i] = fall[i] | rise[i];
      endcase
    end
  end

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (pend[i] && (!found || prio[i] > best_lvl)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = prio[i];
      end
    end
  end

  assign mreq      = found && (best_lvl > cpu_mask);
  assign int_nmi   = nmi_pend;
  assign int_req   = nmi_pend | mreq;
  assign int_index = nmi_pend ? IDX_W'(N_IRQ) : (mreq ? best_idx : '0);
  assign int_level = nmi_pend ? {LVL_W{1'b1}} : (mreq ? best_lvl : '0);
  assign wake      = nmi_pend | (|pend);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata[0] = nmi_rise;
      AW'(1): for (int i = 0; i < N_IRQ; i++) reg_rdata[2*i +: 2] = sense[i];
      AW'(2): reg_rdata[N_IRQ-1:0] = en;
      AW'(3): for (int i = 0; i < HALF; i++) reg_rdata[4*i +: LVL_W] = prio[i];
      AW'(4): for (int i = HALF; i < N_IRQ; i++) reg_rdata[4*(i-HALF) +: LVL_W] = prio[i];
      AW'(5): reg_rdata[N_IRQ-1:0] = flag;
      AW'(6): reg_rdata[0] = nmi_pend;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1       <= '1;
      s2       <= '1;
      s3       <= '1;
      nmi_rise <= 1'b0;
      nmi_pend <= 1'b0;
      en       <= '0;
      flag     <= '0;
      seen     <= '0;
      for (int i = 0; i < N_IRQ; i++) begin
        sense[i] <= '0;
        prio[i]  <= '0;
      end
    end else begin
      s1       <= {nmi_pin, irq_pin};
      s2       <= s1;
      s3       <= s2;
      nmi_pend <= nmi_set | (nmi_pend & ~nmi_ack);
      flag     <= flag_nx;
      seen     <= rd_flag ? flag : (seen & ~clr);
      if (reg_wr) begin
        case (reg_addr)
          AW'(0): nmi_rise <= reg_wdata[0];
          AW'(1): for (int i = 0; i < N_IRQ; i++) sense[i] <= reg_wdata[2*i +: 2];
          AW'(2): en <= reg_wdata[N_IRQ-1:0];
          AW'(3): for (int i = 0; i < HALF; i++) prio[i] <= reg_wdata[4*i +: LVL_W];
          AW'(4): for (int i = HALF; i < N_IRQ; i++) prio[i] <= reg_wdata[4*(i-HALF) +: LVL_W];
          default: ;
        endcase
      end
    end
  end
endmodule

module eirq_ctrl_chk #(
  parameter int N_IRQ = 16,
  parameter int LVL_W = 3,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [LVL_W-1:0] cpu_mask,
  input logic             nmi_ack,
  input logic             int_req,
  input logic             int_nmi,
  input logic [$clog2(N_IRQ+1)-1:0] int_index,
  input logic [LVL_W-1:0] int_level,
  input logic             wake,
  input logic [N_IRQ-1:0] flag
);
  AST_MASK_RULE: assert property (@(posedge clk) disable iff (!rst_n) (int_req && !int_nmi) |-> (int_level > cpu_mask)); // R7
  AST_NMI_TOP: assert property (@(posedge clk) disable iff (!rst_n) int_nmi |-> (int_req && int_index == N_IRQ && int_level == {LVL_W{1'b1}})); // R8
  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (int_nmi && !nmi_ack) |=> int_nmi); // R8
  AST_WAKE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) int_req |-> wake); // R9
  AST_FLAG_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (|(~flag & $past(flag))) |-> $past(reg_wr && reg_addr == AW'(5))); // R4
endmodule

bind eirq_ctrl eirq_ctrl_chk #(.N_IRQ(N_IRQ), .LVL_W(LVL_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .cpu_mask(cpu_mask),
  .nmi_ack(nmi_ack), .int_req(int_req), .int_nmi(int_nmi), .int_index(int_index),
  .int_level(int_level), .wake(wake), .flag(flag)
);

// File: tb/tb_eirq_ctrl.sv
`timescale 1ns/1ps
module tb_eirq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        nmi_pin = 1;
  logic [15:0] irq_pin = '1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2:0]  cpu_mask = '0;
  logic        nmi_ack = 0;
  logic        int_req, int_nmi, wake;
  logic [4:0]  int_index;
  logic [2:0]  int_level;

  eirq_ctrl dut (.*);

  always #2.5 clk = ~clk;

  typedef struct { string tag; int sel; logic [31:0] exp; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] pk(bit r, bit n, int idx, int lvl);
    return {22'd0, r, n, idx[4:0], lvl[2:0]};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = {22'd0, int_req, int_nmi, int_index, int_level};
          1: act = reg_rdata;
          default: act = {31'd0, wake};
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(string tag, int sel, logic [31:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic chk_out(string tag, logic [31:0] exp); push(tag, 0, exp); endtask
  task automatic chk_wake(string tag, bit exp); push(tag, 2, {31'd0, exp}); endtask
  task automatic chk_reg(string tag, logic [2:0] a, logic [31:0] exp);
    @(negedge clk); reg_addr = a; push(tag, 1, exp);
  endtask
  task automatic settle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd5();
    @(negedge clk); reg_rd = 1; reg_addr = 3'd5;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic clear_all(); rd5(); wr(3'd5, 0); settle(1); endtask
  task automatic pulse(int line);
    @(negedge clk); irq_pin[line] = 0; settle(3); irq_pin[line] = 1; settle(5);
  endtask
  task automatic ack();
    @(negedge clk); nmi_ack = 1; @(negedge clk); nmi_ack = 0; settle(1);
  endtask
  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    settle(3); rst_n = 1; settle(3);
    chk_out("R1 outputs idle after reset", pk(0,0,0,0));
    chk_reg("R1 flags clear", 3'd5, 0);
    chk_reg("R1 nmi edge falling", 3'd0, 0);
    chk_wake("R1 wake low", 0);

    wr(3'd2, 32'h0008); wr(3'd3, 32'h0000_5000); wr(3'd1, 32'h40);
    pulse(3);
    chk_out("R2 falling edge line3 offered", pk(1,0,3,5));
    chk_wake("R9 wake on enabled flag", 1);
    wr(3'd5, 0); settle(1);
    chk_reg("R4 write 0 without read keeps flag", 3'd5, 32'h8);
    clear_all();
    chk_reg("R4 read then write 0 clears", 3'd5, 0);
    chk_out("R4 request gone after clear", pk(0,0,0,0));

    wr(3'd1, 32'h840); wr(3'd2, 32'h28);
    @(negedge clk); irq_pin[5] = 0; settle(5);
    chk_reg("R2 rising mode ignores falling", 3'd5, 0);
    irq_pin[5] = 1; settle(5);
    chk_reg("R2 rising edge sets flag", 3'd5, 32'h20);
    chk_out("R7 level 0 not above mask 0", pk(0,0,0,0));
    clear_all();

    wr(3'd1, 32'hC840);
    @(negedge clk); irq_pin[7] = 0; settle(5);
    chk_reg("R2 both edges: falling sets", 3'd5, 32'h80);
    clear_all();
    irq_pin[7] = 1; settle(5);
    chk_reg("R2 both edges: rising sets", 3'd5, 32'h80);
    clear_all();

    @(negedge clk); irq_pin[9] = 0; settle(5);
    chk_reg("R3 low level sets flag", 3'd5, 32'h200);
    rd5(); wr(3'd5, 0); settle(1);
    chk_reg("R3 R4 held low flag survives clear", 3'd5, 32'h200);
    irq_pin[9] = 1; settle(5);
    clear_all();
    chk_reg("R3 flag clears after pin high", 3'd5, 0);

    wr(3'd1, 32'h0010_1010); wr(3'd2, 32'h0444);
    wr(3'd3, 32'h0400_0400); wr(3'd4, 32'h0000_0600);
    @(negedge clk); irq_pin[2] = 0; irq_pin[6] = 0; settle(3);
    irq_pin[2] = 1; irq_pin[6] = 1; settle(5);
    chk_out("R6 tie goes to lower line", pk(1,0,2,4));
    pulse(10);
    chk_out("R6 higher level wins", pk(1,0,10,6));
    @(negedge clk); cpu_mask = 3'd6;
    chk_out("R7 equal to mask blocked", pk(0,0,0,0));
    chk_wake("R9 wake despite mask", 1);
    @(negedge clk); cpu_mask = 3'd5;
    chk_out("R7 above mask offered", pk(1,0,10,6));
    wr(3'd2, 0);
    chk_out("R5 disabled lines not offered", pk(0,0,0,0));
    chk_reg("R5 flags still set when disabled", 3'd5, 32'h444);
    chk_wake("R5 R9 no wake when disabled", 0);
    wr(3'd2, 32'h0444);
    chk_out("R5 re-enabled offered", pk(1,0,10,6));
    clear_all();

    @(negedge clk); cpu_mask = 3'd7; nmi_pin = 0; settle(5);
    chk_out("R8 NMI falling overrides mask", pk(1,1,16,7));
    chk_reg("R8 NMI pending readable", 3'd6, 1);
    nmi_pin = 1; settle(4);
    ack();
    chk_out("R8 NMI cleared by ack", pk(0,0,0,0));
    wr(3'd0, 1);
    @(negedge clk); nmi_pin = 0; settle(5);
    chk_out("R8 rising mode ignores falling", pk(0,0,0,0));
    nmi_pin = 1; settle(5);
    chk_out("R8 NMI rising edge", pk(1,1,16,7));
    chk_wake("R9 wake on NMI", 1);
    ack();
    chk_reg("R8 pending cleared", 3'd6, 0);

    done = 1;
    finish_run();
  end
endmodule